// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Guard Bits

This block multiplies two 32-bit fixed-point operands into an exact product and, each clock cycle, can either hand that product straight to the output, load it into an 80-bit accumulator, add it to the accumulator, or subtract it from the accumulator. The accumulator carries 16 guard bits above the 64-bit product width, so a long run of accumulations can pass the 64-bit range and later come back into it with no loss of precision. Every operation is accepted in one cycle, and its result appears on the outputs after the next rising clock edge.

Each operation carries its own format and readout controls. These select signed or unsigned operands, integer or fractional (1.31) interpretation, saturation of the 32-bit readout, and rounding of a fractional readout. The controls are registered together with the result, so the 32-bit readout and the status flags always describe the most recent accepted operation. The full 80-bit accumulator is also available on its own port.

Top module: `gmac_core`

## Requirements
- R1: With op code 2'b11 (load) in integer mode, the accumulator receives the exact product of the two operands: both sign-extended when signed_i=1, both zero-extended when signed_i=0, and the result sign-extended to 80 bits.
- R2: Op code 2'b00 (multiply only) leaves the accumulator unchanged. The readout, the negative and zero flags and the overflow flag then describe the product alone.
- R3: Op code 2'b01 adds the sign-extended product to the accumulator, and op code 2'b10 subtracts it. One operation is accepted every cycle, and each result is visible after the next rising edge.
- R4: Load (2'b11) discards the previous accumulator contents and replaces them with the current product.
- R5: The accumulator holds sums beyond the signed 64-bit range exactly, in its 16 guard bits, and wraps only at 80 bits.
- R6: In fractional mode with signed operands, the product is shifted left by one bit before use. Unsigned fractional (0.32) products are not shifted.
- R7: With no modifiers, the 32-bit readout is result bits [31:0] in integer mode and bits [63:32] in fractional mode.
- R8: With sat_i=1, a signed readout that does not fit clips to 0x7FFFFFFF or 0x80000000. An unsigned readout clips to 0xFFFFFFFF when too large and to 0 when the result is negative. In signed fractional mode, -1 times -1 reads 0x7FFFFFFF.
- R9: With rnd_i=1 in fractional mode, bits [31:0] are rounded into bit 32, half to even. In integer mode rnd_i has no effect.
- R10: The overflow flag is set when result bits [79:63] are not all equal. For accumulating ops it is sticky and is cleared only by a load whose product fits.
- R11: The negative flag equals result bit 79, and the zero flag is set when all 80 result bits are zero.
- R12: While valid_i=0, the accumulator, readout and flags hold, whatever the other inputs do.
- R13: After reset the accumulator and readout are 0, the zero flag is 1, and the overflow and negative flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation this cycle |
| op_i | input | 2 | 00 multiply, 01 add-accumulate, 10 subtract-accumulate, 11 load |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| signed_i | input | 1 | Operands and readout are signed |
| frac_i | input | 1 | Fractional mode |
| sat_i | input | 1 | Saturate the readout |
| rnd_i | input | 1 | Round a fractional readout |
| acc_o | output | 80 | Accumulator contents |
| res_o | output | 32 | Readout of the latest result |
| ovf_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |

## Verification
The products used include mixed-sign integer pairs, the all-ones unsigned square, and the most negative signed value squared. Together they separate sign extension from zero extension, and show whether the fractional shift is applied. Accumulation is run back to back, and it is driven past 2^64 and then back down to zero, to show that the guard bits hold the carries and that the overflow flag stays sticky. Readout values are built so that their low halves sit just below, at, and just above one half, against both odd and even upper halves; this tells half-even rounding apart from truncation and from plain half-up rounding. Saturation is tried on positive and negative results that are out of range, in both signed and unsigned readout.

// File: rtl/gmac_pkg.sv
`timescale 1ns/1ps
package gmac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_MSB  = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;

  typedef struct packed {
    logic sgn;
    logic frac;
    logic sat;
    logic rnd;
  } rd_mode_t;
endpackage

// File: rtl/gmac_mult.sv
`timescale 1ns/1ps
module gmac_mult #(
  parameter int OPW = 32
) (
  input  logic [OPW-1:0]          a_i,
  input  logic [OPW-1:0]          b_i,
  input  logic                    sgn_i,
  input  logic                    frac_i,
  output logic signed [2*OPW+1:0] prod_o
);
  localparam int XW = OPW + 1;
  localparam int RW = 2 * OPW + 2;

  logic signed [XW-1:0] ax, bx;
  logic signed [RW-1:0] raw;

  // one extra bit makes unsigned operands positive signed values
  assign ax  = {sgn_i & a_i[OPW-1], a_i};
  assign bx  = {sgn_i & b_i[OPW-1], b_i};
  assign raw = RW'(ax) * RW'(bx);

  // 1.31 x 1.31 gives 2.62; realign to 1.63
  assign prod_o = (frac_i && sgn_i) ? (raw <<< 1) : raw;
endmodule

// File: rtl/gmac_accum.sv
`timescale 1ns/1ps
module gmac_accum
  import gmac_pkg::*;
#(
  parameter int PW    = 64,
  parameter int GUARD = 16,
  localparam int AW   = PW + GUARD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  mac_op_e       op_i,
  input  logic [AW-1:0] prod_i,
  output logic [AW-1:0] acc_o,
  output logic [AW-1:0] res_o,
  output logic          ovf_o
);
  logic [AW-1:0] acc_q, res_q, nxt_acc, nxt_res;
  logic          stk_q, ovf_q, nxt_stk, nxt_ovf;

  function automatic logic ovf_of(input logic [AW-1:0] v);
    logic [GUARD:0] top;
    top = v[AW-1:PW-1];
    return !((&top) || !(|top));
  endfunction

  always_comb begin
    nxt_acc = acc_q;
    nxt_res = res_q;
    nxt_stk = stk_q;
    nxt_ovf = ovf_q;
    if (valid_i) begin
      unique case (op_i)
        OP_MUL: begin
          nxt_res = prod_i;
          nxt_ovf = ovf_of(prod_i);
        end
        OP_MAC: begin
          nxt_acc = acc_q + prod_i;
          nxt_res = nxt_acc;
          nxt_stk = stk_q | ovf_of(nxt_acc);
          nxt_ovf = nxt_stk;
        end
        OP_MSB: begin
          nxt_acc = acc_q - prod_i;
          nxt_res = nxt_acc;
          nxt_stk = stk_q | ovf_of(nxt_acc);
          nxt_ovf = nxt_stk;
        end
        default: begin
          nxt_acc = prod_i;
          nxt_res = prod_i;
          nxt_stk = ovf_of(prod_i);
          nxt_ovf = nxt_stk;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
      stk_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= nxt_acc;
      res_q <= nxt_res;
      stk_q <= nxt_stk;
      ovf_q <= nxt_ovf;
    end
  end

  assign acc_o = acc_q;
  assign res_o = res_q;
  assign ovf_o = ovf_q;

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_q) && $stable(res_q) && $stable(ovf_q)));

  assert_sticky_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_q && !(valid_i && op_i == OP_LOAD)) |=> stk_q);
endmodule

// File: rtl/gmac_readout.sv
`timescale 1ns/1ps
module gmac_readout
  import gmac_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int GUARD = 16,
  localparam int PW   = 2 * OPW,
  localparam int AW   = PW + GUARD
) (
  input  logic [AW-1:0]  res_i,
  input  rd_mode_t       mode_i,
  output logic [OPW-1:0] rd_o
);
  localparam int HW = AW - OPW;
  localparam logic [OPW-1:0] HALF = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [OPW-1:0] MAXV = {1'b0, {(OPW-1){1'b1}}};
  localparam logic [OPW-1:0] MINV = {1'b1, {(OPW-1){1'b0}}};

  logic [HW-1:0]  hi, hr;
  logic [OPW-1:0] lo;
  logic [AW-1:0]  val;
  logic           rinc, neg, sfit, ufit;

  assign hi = res_i[AW-1:OPW];
  assign lo = res_i[OPW-1:0];

  always_comb begin
    rinc = 1'b0;
    if (mode_i.frac && mode_i.rnd) begin
      if (lo > HALF)       rinc = 1'b1;
      else if (lo == HALF) rinc = hi[0];  // tie goes to even
    end
    hr   = hi + HW'(rinc);
    val  = mode_i.frac ? {{OPW{hr[HW-1]}}, hr} : res_i;
    neg  = val[AW-1];
    sfit = (&val[AW-1:OPW-1]) | ~(|val[AW-1:OPW-1]);
    ufit = ~(|val[AW-1:OPW]);
    rd_o = val[OPW-1:0];
    if (mode_i.sat) begin
      if (mode_i.sgn) begin
        if (!sfit) rd_o = neg ? MINV : MAXV;
      end else if (neg) begin
        rd_o = '0;
      end else if (!ufit) begin
        rd_o = '1;
      end
    end
  end
endmodule

// File: rtl/gmac_core.sv
`timescale 1ns/1ps
module gmac_core
  import gmac_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int GUARD = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [1:0]               op_i,
  input  logic [OPW-1:0]           a_i,
  input  logic [OPW-1:0]           b_i,
  input  logic                     signed_i,
  input  logic                     frac_i,
  input  logic                     sat_i,
  input  logic                     rnd_i,
  output logic [2*OPW+GUARD-1:0]   acc_o,
  output logic [OPW-1:0]           res_o,
  output logic                     ovf_o,
  output logic                     neg_o,
  output logic                     zero_o
);
  localparam int PW   = 2 * OPW;
  localparam int AW   = PW + GUARD;
  localparam int PEXT = PW + 2;

  mac_op_e                 op_e;
  logic signed [PEXT-1:0]  prod;
  logic [AW-1:0]           prod_x, res_w;
  rd_mode_t                mode_q;

  assign op_e = mac_op_e'(op_i);

  gmac_mult #(.OPW(OPW)) u_mult (
    .a_i    (a_i),
    .b_i    (b_i),
    .sgn_i  (signed_i),
    .frac_i (frac_i),
    .prod_o (prod)
  );

  // sign-extend product into the guard bits
  assign prod_x = {{(AW-PEXT){prod[PEXT-1]}}, prod};

  gmac_accum #(.PW(PW), .GUARD(GUARD)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_e),
    .prod_i  (prod_x),
    .acc_o   (acc_o),
    .res_o   (res_w),
    .ovf_o   (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (valid_i) mode_q <= '{sgn: signed_i, frac: frac_i, sat: sat_i, rnd: rnd_i};
  end

  gmac_readout #(.OPW(OPW), .GUARD(GUARD)) u_rd (
    .res_i  (res_w),
    .mode_i (mode_q),
    .rd_o   (res_o)
  );

  assign neg_o  = res_w[AW-1];
  assign zero_o = ~(|res_w);

  assert_mac_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01) |=> (acc_o == $past(acc_o) + $past(prod_x)));

  assert_mul_keeps_acc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b00) |=> $stable(acc_o));

  assert_zero_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (res_o == '0));

  assert_neg_sat_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.sat && mode_q.sgn && !mode_q.frac && neg_o) |-> res_o[OPW-1]);
endmodule

// File: tb/sim_gmac_core.sv
`timescale 1ns/1ps
module sim_gmac_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] a_i = '0, b_i = '0;
  logic        signed_i = 1'b0, frac_i = 1'b0, sat_i = 1'b0, rnd_i = 1'b0;
  logic [79:0] acc_o;
  logic [31:0] res_o;
  logic        ovf_o, neg_o, zero_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] MUL = 2'b00, MAC = 2'b01, MSB = 2'b10, LD = 2'b11;

  always #2 clk = ~clk;

  gmac_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .frac_i(frac_i),
    .sat_i(sat_i), .rnd_i(rnd_i), .acc_o(acc_o), .res_o(res_o),
    .ovf_o(ovf_o), .neg_o(neg_o), .zero_o(zero_o)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic s, input logic f, input logic sa, input logic r);
    op_i = op; a_i = a; b_i = b; signed_i = s; frac_i = f; sat_i = sa; rnd_i = r;
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic f, input logic sa, input logic r);
    @(negedge clk);
    put(op, a, b, s, f, sa, r);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R13 acc", acc_o, 80'h0);
    chk("R13 res", res_o, 80'h0);
    chk("R13 zero", zero_o, 1);
    chk("R13 ovf", ovf_o, 0);
    chk("R13 neg", neg_o, 0);
  endtask

  task automatic t_product;
    issue(LD, 32'hFFFF_FFFD, 32'd7, 1, 0, 0, 0);
    chk("R1 signed acc", acc_o, 80'hFFFF_FFFF_FFFF_FFFF_FFEB);
    chk("R1 signed res", res_o, 32'hFFFF_FFEB);
    chk("R11 neg", neg_o, 1);
    issue(LD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R1 unsigned acc", acc_o, 80'h0000_FFFF_FFFE_0000_0001);
    chk("R1 unsigned res", res_o, 32'h1);
    chk("R11 pos", neg_o, 0);
  endtask

  task automatic t_mul_only;
    issue(MUL, 32'd2, 32'd3, 1, 0, 0, 0);
    chk("R2 acc kept", acc_o, 80'h0000_FFFF_FFFE_0000_0001);
    chk("R2 res prod", res_o, 32'd6);
  endtask

  task automatic t_accum;
    @(negedge clk);
    put(LD, 32'd10, 32'd10, 1, 0, 0, 0);
    valid_i = 1'b1;
    @(negedge clk);
    chk("R3 c1", acc_o, 80'd100);
    put(MAC, 32'd5, 32'd4, 1, 0, 0, 0);
    @(negedge clk);
    chk("R3 c2 add", acc_o, 80'd120);
    put(MSB, 32'd3, 32'd50, 1, 0, 0, 0);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R3 c3 sub", acc_o, 80'hFFFF_FFFF_FFFF_FFFF_FFE2);
    chk("R3 res", res_o, 32'hFFFF_FFE2);
  endtask

  task automatic t_load;
    issue(LD, 32'd2, 32'd3, 1, 0, 0, 0);
    chk("R4 load", acc_o, 80'd6);
    chk("R4 zero", zero_o, 0);
  endtask

  task automatic t_guard;
    issue(LD, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0);
    chk("R5 2^62", acc_o, 80'h0000_4000_0000_0000_0000);
    chk("R10 no ovf", ovf_o, 0);
    issue(MAC, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0);
    chk("R10 ovf at 2^63", ovf_o, 1);
    issue(MAC, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0);
    issue(MAC, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0);
    chk("R5 2^64", acc_o, 80'h0001_0000_0000_0000_0000);
    for (int i = 0; i < 4; i++) issue(MSB, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0);
    chk("R5 back to 0", acc_o, 80'h0);
    chk("R11 zero", zero_o, 1);
    chk("R10 sticky", ovf_o, 1);
    issue(LD, 32'd1, 32'd1, 1, 0, 0, 0);
    chk("R10 cleared", ovf_o, 0);
    issue(MUL, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, 0);
    chk("R10 mul ovf", ovf_o, 1);
    chk("R8 -1*-1 sat", res_o, 32'h7FFF_FFFF);
    issue(MAC, 32'd0, 32'd0, 1, 0, 0, 0);
    chk("R10 mul not sticky", ovf_o, 0);
    chk("R2 acc after mul", acc_o, 80'd1);
  endtask

  task automatic t_frac;
    issue(LD, 32'h4000_0000, 32'h4000_0000, 1, 1, 0, 0);
    chk("R6 shifted acc", acc_o, 80'h0000_2000_0000_0000_0000);
    chk("R7 frac res", res_o, 32'h2000_0000);
    issue(LD, 32'h8000_0000, 32'h8000_0000, 0, 1, 0, 0);
    chk("R6 unsigned no shift", acc_o, 80'h0000_4000_0000_0000_0000);
    chk("R7 unsigned frac res", res_o, 32'h4000_0000);
    issue(MUL, 32'h8000_0000, 32'h8000_0000, 1, 1, 0, 0);
    chk("R7 unsat -1*-1", res_o, 32'h8000_0000);
  endtask

  task automatic t_sat;
    issue(LD, 32'h0001_0000, 32'h0001_0000, 1, 0, 1, 0);
    chk("R8 pos clip", res_o, 32'h7FFF_FFFF);
    issue(LD, 32'h0001_0000, 32'h0001_0000, 1, 0, 0, 0);
    chk("R7 int no sat", res_o, 32'h0);
    issue(LD, 32'hFFFF_0000, 32'h0001_0000, 1, 0, 1, 0);
    chk("R8 neg clip", res_o, 32'h8000_0000);
    issue(LD, 32'h0001_0000, 32'h0001_0000, 0, 0, 1, 0);
    chk("R8 unsigned clip", res_o, 32'hFFFF_FFFF);
    issue(LD, 32'd0, 32'd0, 0, 0, 0, 0);
    issue(MSB, 32'd1, 32'd1, 0, 0, 1, 0);
    chk("R8 unsigned neg to 0", res_o, 32'h0);
    chk("R11 neg", neg_o, 1);
    issue(MSB, 32'd0, 32'd0, 0, 0, 0, 0);
    chk("R8 unsigned no sat", res_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_round;
    issue(LD, 32'h0001_8000, 32'h0001_0000, 1, 0, 0, 0);
    issue(MAC, 32'd0, 32'd0, 1, 1, 0, 1);
    chk("R9 tie odd up", res_o, 32'd2);
    issue(MAC, 32'd0, 32'd0, 1, 1, 0, 0);
    chk("R9 truncate", res_o, 32'd1);
    issue(MSB, 32'd1, 32'd1, 1, 0, 0, 0);
    issue(MAC, 32'd0, 32'd0, 1, 1, 0, 1);
    chk("R9 below half", res_o, 32'd1);
    issue(LD, 32'h0002_8000, 32'h0001_0000, 1, 0, 0, 0);
    issue(MAC, 32'd0, 32'd0, 1, 1, 0, 1);
    chk("R9 tie even stays", res_o, 32'd2);
    issue(MAC, 32'd1, 32'd1, 1, 0, 0, 0);
    issue(MAC, 32'd0, 32'd0, 1, 1, 0, 1);
    chk("R9 above half", res_o, 32'd3);
    issue(LD, 32'h0001_8000, 32'h0001_0000, 1, 0, 0, 1);
    chk("R9 int ignores rnd", res_o, 32'h8000_0000);
  endtask

  task automatic t_idle;
    logic [79:0] a0;
    logic [31:0] r0;
    logic        o0;
    issue(LD, 32'd0, 32'd0, 0, 0, 0, 0);
    issue(MSB, 32'd1, 32'd1, 0, 0, 0, 0);
    a0 = acc_o; r0 = res_o; o0 = ovf_o;
    @(negedge clk);
    put(LD, 32'd5, 32'd5, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    chk("R12 acc hold", acc_o, a0);
    chk("R12 res hold", res_o, r0);
    chk("R12 ovf hold", ovf_o, o0);
    chk("R12 res value", res_o, 32'hFFFF_FFFF);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_product();
    t_mul_only();
    t_accum();
    t_load();
    t_guard();
    t_frac();
    t_sat();
    t_round();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule